// File: doc/BRIEF.md
# Multiprocessor-Capable UART Transmitter

This block turns one byte, written through a single-cycle strobe, into an asynchronous serial frame on a line that rests high. A frame is a low start bit, then 7 or 8 data bits with the least significant first, then an optional extra bit, then one or two high stop bits. The extra bit is either a parity bit (even or odd) or, in multiprocessor mode, an address/data marker bit whose value software chooses. In multiprocessor mode that marker takes the slot that parity would use, and parity is never sent.

Bit timing comes from outside: a one-cycle `bit_tick` pulse marks each bit boundary, so baud generation stays in a separate divider. An accepted byte waits for the next tick, and each bit then lasts exactly one tick interval. All configuration inputs are captured with the byte, so software may change them for the next frame while the current frame is still on the line. `busy` covers the whole frame, and strobes that arrive while it is high are dropped.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset `busy` is 0 and `txd` is 1. Whenever `busy` is 0, `txd` is 1.
- R2: A strobe `wr_en`=1 while `busy`=0 is accepted: `busy` is 1 from the next cycle. The start bit (`txd`=0) begins at the next `bit_tick`, and every frame bit lasts one tick interval.
- R3: Data bits follow the start bit, least significant bit first. With `len8`=1 bits 7:0 are sent. With `len8`=0 only bits 6:0 are sent and bit 7 is ignored.
- R4: With `par_en`=1 and `mp_en`=0, one parity bit follows the data. The parity covers only the data bits sent. With `par_odd`=0 the ones in data plus parity are even. With `par_odd`=1 they are odd.
- R5: With `mp_en`=1, exactly one bit equal to `mp_bit` follows the data, and no parity bit is sent whatever `par_en` is.
- R6: `two_stop`=0 ends the frame with one stop bit and `two_stop`=1 with two. Stop bits are 1.
- R7: `busy` stays 1 until the `bit_tick` that ends the last stop bit and falls at that tick, so a frame of N bits keeps `busy` high for N tick intervals after the first tick.
- R8: A strobe while `busy`=1 is ignored: the frame on the line is unchanged and no extra frame follows.
- R9: The data and all configuration inputs are sampled at acceptance. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit-time enable |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity enable (ignored in multiprocessor mode) |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| mp_en | input | 1 | Multiprocessor mode enable |
| mp_bit | input | 1 | Value of the multiprocessor bit |
| busy | output | 1 | Frame pending or on the line |
| txd | output | 1 | Serial output, idles high |

## Verification
The assertions check on every cycle that the line rests high while the block is idle and that a start bit is loaded at the first tick after acceptance. They also check that the shift state does not move between ticks even when strobes arrive during a frame, and that `busy` falls only on a tick with a live bit count behind it. Bit order, parity sense, the multiprocessor bit replacing parity, the stop-bit count and the capture of configuration at acceptance can only be shown by the bench's frames. The bench compares each sampled line bit with a frame it builds itself from random and directed bytes and settings.

// File: rtl/mp_uart_tx_pkg.sv
package mp_uart_tx_pkg;

   typedef struct packed {
      logic len8;
      logic par_en;
      logic par_odd;
      logic two_stop;
      logic mp_en;
      logic mp_bit;
   } tx_cfg_t;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_PEND = 2'd1,
      TX_SEND = 2'd2
   } tx_state_t;

endpackage

// File: rtl/mp_uart_tx_frame.sv
module mp_uart_tx_frame
   import mp_uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = 1 + DATA_W + 1 + 2,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  tx_cfg_t            cfg,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);

   localparam int SHORT_W = DATA_W - 1;

   logic [DATA_W-1:0] mask;
   logic              par_bit;
   logic              has_extra;
   logic              extra_val;
   int                dlen;

   // data-length mask: parity must cover only the bits that go out (R3, R4)
   always_comb begin
      dlen = cfg.len8 ? DATA_W : SHORT_W;
      for (int i = 0; i < DATA_W; i++) begin
         mask[i] = (i < dlen);
      end
   end

   assign par_bit   = (^(data & mask)) ^ cfg.par_odd;
   assign has_extra = cfg.mp_en | cfg.par_en;
   assign extra_val = cfg.mp_en ? cfg.mp_bit : par_bit;

   // frame vector, LSB leaves first; bits above the frame stay 1
   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (mask[i]) begin
            frame[1 + i] = data[i];
         end
      end
      if (has_extra) begin
         frame[1 + dlen] = extra_val;
      end
      nbits = CNT_W'(1 + dlen) + CNT_W'(has_extra) + (cfg.two_stop ? CNT_W'(2) : CNT_W'(1));
   end

endmodule

// File: rtl/mp_uart_tx_shift.sv
module mp_uart_tx_shift
   import mp_uart_tx_pkg::*;
#(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = $clog2(FRAME_W + 1),
   parameter bit REG_TXD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               busy,
   output logic               txd
);

   tx_state_t          state;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;
   logic               line_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         shreg <= '1;
         left  <= '0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (load) begin
                  shreg <= frame;
                  left  <= nbits;
                  state <= TX_PEND;
               end
            end
            TX_PEND: begin
               if (bit_tick) begin
                  state <= TX_SEND;
               end
            end
            TX_SEND: begin
               if (bit_tick) begin
                  shreg <= {1'b1, shreg[FRAME_W-1:1]};
                  left  <= left - CNT_W'(1);
                  if (left == CNT_W'(1)) begin
                     state <= TX_IDLE;
                  end
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign busy     = (state != TX_IDLE);
   assign line_bit = (state == TX_SEND) ? shreg[0] : 1'b1;

   generate
      if (REG_TXD) begin : g_txd_reg
         logic txd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) txd_q <= 1'b1;
            else        txd_q <= line_bit;
         end
         assign txd = txd_q;
      end else begin : g_txd_comb
         assign txd = line_bit;
      end
   endgenerate

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_PEND && bit_tick) |=> (state == TX_SEND && shreg[0] == 1'b0));

   assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_tick) |=> ($stable(shreg) && $stable(left)));

   assert_live_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_SEND) |-> (left != '0));

   assert_busy_ends_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(bit_tick));

endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
   import mp_uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_TXD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              len8,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              mp_en,
   input  logic              mp_bit,
   output logic              busy,
   output logic              txd
);

   localparam int FRAME_W = 1 + DATA_W + 1 + 2;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mp_uart_tx: DATA_W must be at least 2");
      end
   endgenerate

   tx_cfg_t            cfg;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               load;

   assign cfg  = '{len8: len8, par_en: par_en, par_odd: par_odd,
                   two_stop: two_stop, mp_en: mp_en, mp_bit: mp_bit};
   assign load = wr_en & ~busy;

   mp_uart_tx_frame #(
      .DATA_W  (DATA_W),
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_frame (
      .data  (wr_data),
      .cfg   (cfg),
      .frame (frame),
      .nbits (nbits)
   );

   mp_uart_tx_shift #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W),
      .REG_TXD (REG_TXD)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .load     (load),
      .frame    (frame),
      .nbits    (nbits),
      .busy     (busy),
      .txd      (txd)
   );

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy) |=> busy);

endmodule

// File: tb/test_mp_uart_tx.sv
module test_mp_uart_tx;

   localparam int TDIV = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0;
   logic       two_stop = 1'b0, mp_en = 1'b0, mp_bit = 1'b0;
   logic       busy, txd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mp_uart_tx i_mp_uart_tx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
      .wr_data(wr_data), .len8(len8), .par_en(par_en), .par_odd(par_odd),
      .two_stop(two_stop), .mp_en(mp_en), .mp_bit(mp_bit),
      .busy(busy), .txd(txd)
   );

   int tcnt = 0;
   always @(posedge clk) begin
      tcnt     <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      bit_tick <= (tcnt == TDIV - 1);
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // expected frame: index 0 is sent first
   function automatic int build(input logic [7:0] d, input logic l8, input logic pe,
                                input logic po, input logic ts, input logic me,
                                input logic mb, output logic [11:0] f);
      int n = 0;
      int nd = l8 ? 8 : 7;
      logic p = po;
      f = '1;
      f[n++] = 1'b0;
      for (int i = 0; i < nd; i++) begin
         f[n++] = d[i];
         p ^= d[i];
      end
      if (me)      f[n++] = mb;
      else if (pe) f[n++] = p;
      f[n++] = 1'b1;
      if (ts) f[n++] = 1'b1;
      return n;
   endfunction

   task automatic wait_tick();
      do @(posedge clk); while (!bit_tick);
   endtask

   // send one frame, optionally scrambling inputs while busy (R8, R9)
   task automatic send(input logic [7:0] d, input logic l8, input logic pe,
                       input logic po, input logic ts, input logic me,
                       input logic mb, input bit scramble);
      logic [11:0] f;
      int n;
      string req;
      n = build(d, l8, pe, po, ts, me, mb, f);
      while (busy) @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; len8 = l8; par_en = pe; par_odd = po;
      two_stop = ts; mp_en = me; mp_bit = mb;
      @(posedge clk);
      @(negedge clk);
      check("R2", busy, 1'b1, "busy after accept");
      check("R2", txd, 1'b1, "line high before first tick");
      if (scramble) begin
         wr_en = 1'b1; wr_data = ~d; len8 = ~l8; par_en = ~pe; par_odd = ~po;
         two_stop = ~ts; mp_en = ~me; mp_bit = ~mb;
      end else begin
         wr_en = 1'b0;
      end
      for (int k = 0; k < n; k++) begin
         wait_tick();
         repeat (3) @(negedge clk);
         if (k == 0)                  req = "R2";
         else if (k <= (l8 ? 8 : 7))  req = "R3";
         else if (k >= n - (ts ? 2 : 1)) req = "R6";
         else                         req = me ? "R5" : "R4";
         if (scramble) req = {req, "/R9"};
         check(req, txd, f[k], $sformatf("bit %0d of 0x%02h", k, d));
         check("R7", busy, 1'b1, $sformatf("busy during bit %0d", k));
         if (k == 0) wr_en = 1'b0;
      end
      wait_tick();
      @(negedge clk);
      check(scramble ? "R7/R8" : "R7", busy, 1'b0, "busy after last stop");
      check("R1", txd, 1'b1, "idle line after frame");
      // no extra frame may follow a dropped strobe (R8)
      if (scramble) begin
         repeat (2) wait_tick();
         repeat (3) @(negedge clk);
         check("R8", busy, 1'b0, "no frame from ignored strobe");
         check("R8", txd, 1'b1, "line idle after ignored strobe");
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", busy, 1'b0, "busy in reset");
      check("R1", txd, 1'b1, "txd in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", busy, 1'b0, "busy after reset");
      check("R1", txd, 1'b1, "txd after reset");

      // directed corners
      send(8'h00, 1, 0, 0, 0, 0, 0, 0);           // R3 8N1 all zero
      send(8'hFF, 1, 0, 0, 1, 0, 0, 0);           // R6 two stops
      send(8'hA5, 1, 1, 0, 0, 0, 0, 0);           // R4 even
      send(8'hA4, 1, 1, 1, 0, 0, 0, 0);           // R4 odd
      send(8'h81, 0, 1, 0, 0, 0, 0, 0);           // R3/R4 bit 7 ignored in parity
      send(8'h80, 0, 1, 1, 1, 0, 0, 0);           // R3 7-bit, odd, two stops
      send(8'h3C, 1, 1, 0, 0, 1, 1, 0);           // R5 mp=1 overrides parity
      send(8'h3D, 0, 1, 1, 1, 1, 0, 0);           // R5 mp=0, 7-bit
      send(8'h5A, 1, 1, 0, 1, 0, 0, 1);           // R8/R9 scramble
      send(8'hC3, 0, 0, 1, 0, 1, 1, 1);           // R8/R9 scramble in mp mode

      // constrained random frames, back to back
      for (int t = 0; t < 200; t++) begin
         logic [7:0] r = 8'($urandom);
         logic [6:0] c = 7'($urandom);
         send(r, c[0], c[1], c[2], c[3], c[4], c[5], (c[6] & c[0]));
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
         $finish;
      end
   end

endmodule